// File: doc/BRIEF.md
# APB Interrupt Controller, 64 Sources

This block gathers 64 interrupt inputs and presents them to a processor as one request line. Each input is either level-sensitive, where the live synchronized level is what counts, or edge-captured, where a rising edge sets a sticky flag. A sticky flag holds until software clears it. A build-time parameter chooses which inputs are edge-captured.

Between the inputs and the pending view sit 64 channel slots. Each slot names, through a 6-bit routing field, the source it watches. A slot shows pending when its enable bit is set and the routed source is active. The request line rises when the global enable is on and at least one slot is pending.

Software reaches everything through a zero-wait-state APB slave port. Pending, enable and flag state each appear as a low word (slots or sources 0 to 31) and a high word (32 to 63).

Top module: `apb_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq_o` is 0 and every routing slot selects source 0.
- R2: Bit 31 of the control word at offset 0x00 is the global enable; with it clear `irq_o` stays 0. Other control bits read 0.
- R3: The enable words sit at 0x10 (slots 0 to 31) and 0x28 (slots 32 to 63); a 1 in bit k lets slot k become pending, a 0 keeps it at 0.
- R4: For an edge-captured source, a rising edge on its synchronized input sets its bit in the flag word (0x08 for sources 0 to 31, 0x20 for 32 to 63). The bit stays set after the input falls. Flag bits of level sources read 0.
- R5: Writing a flag word clears each bit written as 0 and keeps each bit written as 1. An edge arriving in the same cycle as a clear leaves the bit set.
- R6: Bit k of the pending words (0x14 low, 0x2c high) is enable bit k AND the state of the source routed to slot k. That state is the flag for edge-captured sources and the live synchronized level for level sources. `irq_o` is registered and equals global enable AND any pending bit, one cycle later.
- R7: The routing words start at 0x40, one every 4 bytes, 16 words in all. Word w holds slot 4w in bits 29:24, slot 4w+1 in bits 21:16, slot 4w+2 in bits 13:8 and slot 4w+3 in bits 5:0. The two upper bits of each byte read 0.
- R8: Reads of unmapped offsets return 0, and writes to them change nothing. Any address with bits above bit 7 set counts as unmapped. `pready` is always 1 and `pslverr` always 0.
- R9: A level source's pending bit falls when its input falls, with no software action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error, always 0 |
| irq_src | input | 64 | Interrupt source inputs |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The level path is driven with several input patterns and enable masks under identity routing:
- a single low-word source;
- the top bit of the low word;
- a mixed pattern across both words with partial masks;
- all inputs high, both with everything enabled and with everything masked.

These patterns tell a crossed bank or a missing mask apart from correct gating. A scrambled routing word shows whether byte order within a word is reversed. An edge pulse lasting one cycle shows that capture is sticky. A clear timed to meet an incoming edge shows which of the two wins.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int NSRC   = 64;
   localparam int BANK_W = 32;
   localparam int SEL_W  = $clog2(NSRC);
   localparam logic [7:0] A_CTRL   = 8'h00;
   localparam logic [7:0] A_FLG_LO = 8'h08;
   localparam logic [7:0] A_ENA_LO = 8'h10;
   localparam logic [7:0] A_PND_LO = 8'h14;
   localparam logic [7:0] A_FLG_HI = 8'h20;
   localparam logic [7:0] A_ENA_HI = 8'h28;
   localparam logic [7:0] A_PND_HI = 8'h2C;
   localparam logic [1:0] A_RT_SEG = 2'b01;
   localparam int GEN_BIT = 31;
endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
   parameter int         N       = 64,
   parameter int         STAGES  = 2,
   parameter logic [N-1:0] PULSE = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o,
   output logic [N-1:0] state_o
);
   logic [N-1:0] sync_q [STAGES];
   logic [N-1:0] prev_q;
   logic [N-1:0] flag_q;
   logic [N-1:0] live;
   logic [N-1:0] rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) sync_q[s] <= '0;
         prev_q <= '0;
      end else begin
         sync_q[0] <= src_i;
         for (int s = 1; s < STAGES; s++) sync_q[s] <= sync_q[s-1];
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign live = sync_q[STAGES-1];
   assign rise = live & ~prev_q;

   for (genvar i = 0; i < N; i++) begin : g_bit
      if (PULSE[i]) begin : g_edge
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       flag_q[i] <= 1'b0;
            else if (rise[i]) flag_q[i] <= 1'b1;
            else if (clr_i[i]) flag_q[i] <= 1'b0;
         end
         assign state_o[i] = flag_q[i];
      end else begin : g_level
         assign flag_q[i]  = 1'b0;
         assign state_o[i] = live[i];
      end
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/irqc_route.sv
module irqc_route #(
   parameter int NSLOT = 64,
   parameter int SW    = 6
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_i,
   input  logic [$clog2(NSLOT/4)-1:0]     widx_i,
   input  logic [31:0]                    wdata_i,
   input  logic [$clog2(NSLOT/4)-1:0]     ridx_i,
   output logic [31:0]                    rdata_o,
   input  logic [(1<<SW)-1:0]             state_i,
   input  logic [NSLOT-1:0]               en_i,
   output logic [NSLOT-1:0]               pend_o
);
   localparam int NWORD = NSLOT / 4;
   localparam int IW    = $clog2(NWORD);

   logic [SW-1:0] sel_q [NSLOT];

   for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      localparam int LANE = 3 - (k % 4);
      localparam logic [IW-1:0] WRD = IW'(k / 4);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      sel_q[k] <= '0;
         else if (wr_i && widx_i == WRD)  sel_q[k] <= wdata_i[8*LANE +: SW];
      end
      assign pend_o[k] = en_i[k] & state_i[sel_q[k]];
   end

   always_comb begin
      rdata_o = '0;
      for (int j = 0; j < 4; j++)
         rdata_o[8*(3-j) +: SW] = sel_q[4*ridx_i + j];
   end
endmodule

// File: rtl/apb_irq_ctrl.sv
module apb_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int          ADDR_W      = 12,
   parameter int          SYNC_STAGES = 2,
   parameter logic [63:0] PULSE_SRC   = 64'hFFFF_0000_0000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   output logic              pready,
   output logic              pslverr,
   input  logic [63:0]       irq_src,
   output logic              irq_o
);
   localparam int NSLOT = NSRC;
   localparam int IW    = $clog2(NSLOT / 4);

   if (ADDR_W < 9) begin : g_bad_addr
      $error("apb_irq_ctrl: ADDR_W must be at least 9");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("apb_irq_ctrl: SYNC_STAGES must be at least 2");
   end

   logic              wr;
   logic              in_map;
   logic              rt_hit;
   logic [7:0]        off;
   logic              global_en_q;
   logic [NSLOT-1:0]  en_q;
   logic [NSRC-1:0]   flag;
   logic [NSRC-1:0]   state;
   logic [NSRC-1:0]   clr;
   logic [NSLOT-1:0]  pend;
   logic [31:0]       rt_rdata;
   logic              irq_q;

   assign wr      = psel & penable & pwrite;
   assign off     = paddr[7:0];
   assign in_map  = (paddr[ADDR_W-1:8] == '0);
   assign rt_hit  = in_map && (off[7:6] == A_RT_SEG);
   assign pready  = 1'b1;
   assign pslverr = 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         global_en_q <= 1'b0;
         en_q        <= '0;
      end else if (wr && in_map) begin
         case (off)
            A_CTRL:   global_en_q            <= pwdata[GEN_BIT];
            A_ENA_LO: en_q[BANK_W-1:0]       <= pwdata;
            A_ENA_HI: en_q[NSLOT-1:BANK_W]   <= pwdata;
            default: ;
         endcase
      end
   end

   assign clr[BANK_W-1:0]    = (wr && in_map && off == A_FLG_LO) ? ~pwdata : '0;
   assign clr[NSRC-1:BANK_W] = (wr && in_map && off == A_FLG_HI) ? ~pwdata : '0;

   irqc_capture #(.N(NSRC), .STAGES(SYNC_STAGES), .PULSE(PULSE_SRC)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_i   (irq_src),
      .clr_i   (clr),
      .flag_o  (flag),
      .state_o (state)
   );

   irqc_route #(.NSLOT(NSLOT), .SW(SEL_W)) u_rt (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr && rt_hit),
      .widx_i  (paddr[IW+1:2]),
      .wdata_i (pwdata),
      .ridx_i  (paddr[IW+1:2]),
      .rdata_o (rt_rdata),
      .state_i (state),
      .en_i    (en_q),
      .pend_o  (pend)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= global_en_q & (|pend);
   end
   assign irq_o = irq_q;

   always_comb begin
      prdata = '0;
      if (rt_hit) begin
         prdata = rt_rdata;
      end else if (in_map) begin
         case (off)
            A_CTRL:   prdata[GEN_BIT] = global_en_q;
            A_FLG_LO: prdata = flag[BANK_W-1:0];
            A_FLG_HI: prdata = flag[NSRC-1:BANK_W];
            A_ENA_LO: prdata = en_q[BANK_W-1:0];
            A_ENA_HI: prdata = en_q[NSLOT-1:BANK_W];
            A_PND_LO: prdata = pend[BANK_W-1:0];
            A_PND_HI: prdata = pend[NSLOT-1:BANK_W];
            default:  prdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic              global_en,
   input logic [63:0]       flag,
   input logic [63:0]       pend,
   input logic              irq_o
);
   logic flag_wr;
   assign flag_wr = psel && penable && pwrite && (paddr[ADDR_W-1:8] == '0) &&
                    (paddr[7:0] == 8'h08 || paddr[7:0] == 8'h20);

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !global_en |=> !irq_o);                                          // R2

   AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
      (global_en && (pend != '0)) |=> irq_o);                          // R6

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |=> !irq_o);                                        // R6

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_wr |=> ((flag & $past(flag)) == $past(flag)));             // R4
endmodule

bind apb_irq_ctrl irqc_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .psel      (psel),
   .penable   (penable),
   .pwrite    (pwrite),
   .paddr     (paddr),
   .global_en (global_en_q),
   .flag      (flag),
   .pend      (pend),
   .irq_o     (irq_o)
);

// File: tb/tb_apb_irq_ctrl.sv
`timescale 1ns/1ps
module tb_apb_irq_ctrl;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [AW-1:0] paddr = '0;
   logic [31:0]   pwdata = '0;
   logic [31:0]   prdata;
   logic          pready, pslverr;
   logic [63:0]   irq_src = '0;
   logic          irq_o;

   int n_run = 0;
   int n_bad = 0;
   logic [31:0] rd;

   always #4 clk = ~clk;

   apb_irq_ctrl #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
      .pslverr(pslverr), .irq_src(irq_src), .irq_o(irq_o)
   );

   typedef struct packed {
      logic [47:0] lvl;
      logic [31:0] en_lo;
      logic [31:0] en_hi;
      logic [31:0] exp_lo;
      logic [31:0] exp_hi;
   } vec_t;

   localparam vec_t VECS [5] = '{
      '{48'h0000_0000_0001, 32'h0000_0001, 32'h0,         32'h0000_0001, 32'h0},
      '{48'h0000_8000_0000, 32'hFFFF_FFFF, 32'h0,         32'h8000_0000, 32'h0},
      '{48'hABCD_1234_5678, 32'h0000_FFFF, 32'h0000_00FF, 32'h0000_5678, 32'h0000_00CD},
      '{48'hFFFF_FFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_FFFF},
      '{48'hFFFF_FFFF_FFFF, 32'h0,         32'h0,         32'h0,         32'h0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic apb_wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
      @(negedge clk);
      penable = 1'b1;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
      @(negedge clk);
      penable = 1'b1;
      #1 d = prdata;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic identity_routes();
      for (int w = 0; w < 16; w++)
         apb_wr(AW'(12'h40 + 4*w), (32'(4*w) * 32'h0101_0101) | 32'h0001_0203);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_run++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin : main
      cyc(3);
      rst_n = 1'b1;
      cyc(2);

      // R1: reset state
      check("R1 irq_o", {31'b0, irq_o}, 32'h0);
      apb_rd(12'h000, rd); check("R1 ctrl", rd, 32'h0);
      apb_rd(12'h010, rd); check("R1 en_lo", rd, 32'h0);
      apb_rd(12'h028, rd); check("R1 en_hi", rd, 32'h0);
      apb_rd(12'h020, rd); check("R1 flag_hi", rd, 32'h0);
      apb_rd(12'h05C, rd); check("R1 route word", rd, 32'h0);
      check("R8 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);

      // R2: global enable gating
      irq_src[0] = 1'b1;
      apb_wr(12'h010, 32'h1);
      cyc(6);
      check("R2 irq off while gen clear", {31'b0, irq_o}, 32'h0);
      apb_wr(12'h000, 32'hFFFF_FFFF);
      apb_rd(12'h000, rd); check("R2 ctrl readback", rd, 32'h8000_0000);
      cyc(2);
      check("R2 irq on with gen", {31'b0, irq_o}, 32'h1);

      // R9: level falls without software
      irq_src[0] = 1'b0;
      cyc(5);
      apb_rd(12'h014, rd); check("R9 pend drops", rd, 32'h0);
      check("R9 irq drops", {31'b0, irq_o}, 32'h0);

      // R3/R6: table of level patterns under identity routing
      identity_routes();
      for (int v = 0; v < 5; v++) begin
         irq_src = {16'h0, VECS[v].lvl};
         apb_wr(12'h010, VECS[v].en_lo);
         apb_wr(12'h028, VECS[v].en_hi);
         cyc(5);
         apb_rd(12'h014, rd); check("R3/R6 pend_lo", rd, VECS[v].exp_lo);
         apb_rd(12'h02C, rd); check("R3/R6 pend_hi", rd, VECS[v].exp_hi);
         check("R6 irq vector", {31'b0, irq_o},
               {31'b0, |{VECS[v].exp_lo, VECS[v].exp_hi}});
      end
      irq_src = '0;
      apb_rd(12'h008, rd); check("R4 level flags read zero", rd, 32'h0);

      // R7: routing byte order and field width
      apb_wr(12'h040, 32'hFF0A_0F14);
      apb_rd(12'h040, rd); check("R7 route readback", rd, 32'h3F0A_0F14);
      apb_wr(12'h040, 32'h050A_0F14);
      apb_wr(12'h010, 32'h0000_000F);
      apb_wr(12'h028, 32'h0);
      irq_src[15] = 1'b1;
      cyc(5);
      apb_rd(12'h014, rd); check("R7 slot2 sees source 15", rd, 32'h0000_0004);
      irq_src[15] = 1'b0;
      irq_src[5]  = 1'b1;
      cyc(5);
      apb_rd(12'h014, rd); check("R7 slot0 sees source 5", rd, 32'h0000_0001);
      irq_src[5] = 1'b0;
      identity_routes();
      apb_wr(12'h010, 32'h0);

      // R4: one-cycle pulse on edge-captured source 50
      apb_wr(12'h028, 32'h0004_0000);
      @(negedge clk); irq_src[50] = 1'b1;
      @(negedge clk); irq_src[50] = 1'b0;
      cyc(5);
      apb_rd(12'h020, rd); check("R4 flag held after pulse", rd, 32'h0004_0000);
      apb_rd(12'h02C, rd); check("R4 pend from flag", rd, 32'h0004_0000);
      check("R4 irq from flag", {31'b0, irq_o}, 32'h1);

      // R5: write-one keeps, write-zero clears
      apb_wr(12'h020, 32'hFFFF_FFFF);
      apb_rd(12'h020, rd); check("R5 write one keeps", rd, 32'h0004_0000);
      apb_wr(12'h020, 32'hFFFB_FFFF);
      apb_rd(12'h020, rd); check("R5 write zero clears", rd, 32'h0);
      cyc(2);
      check("R5 irq after clear", {31'b0, irq_o}, 32'h0);

      // R5: edge on source 49 meets a clear in the same cycle
      @(negedge clk); irq_src[49] = 1'b1;
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b1; paddr = 12'h020; pwdata = 32'hFFFD_FFFF; penable = 1'b0;
      @(negedge clk);
      penable = 1'b1;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
      apb_rd(12'h020, rd); check("R5 set wins over clear", rd, 32'h0002_0000);
      irq_src[49] = 1'b0;
      apb_wr(12'h020, 32'h0);

      // R8: unmapped offsets
      apb_wr(12'h010, 32'h0000_00A5);
      apb_wr(12'h004, 32'hFFFF_FFFF);
      apb_wr(12'h03C, 32'hFFFF_FFFF);
      apb_wr(12'h110, 32'hFFFF_FFFF);
      apb_wr(12'h140, 32'hFFFF_FFFF);
      apb_rd(12'h010, rd); check("R8 enable untouched", rd, 32'h0000_00A5);
      apb_rd(12'h040, rd); check("R8 route untouched", rd, 32'h0001_0203);
      apb_rd(12'h004, rd); check("R8 read 0x04", rd, 32'h0);
      apb_rd(12'h03C, rd); check("R8 read 0x3C", rd, 32'h0);
      apb_rd(12'h110, rd); check("R8 read alias 0x110", rd, 32'h0);
      apb_rd(12'h140, rd); check("R8 read alias 0x140", rd, 32'h0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule